// File: doc/BRIEF.md
# Banked Data Address Translator

This block sits between a small processor's 8-bit data address and a 16-bit physical data memory. The upper half of the 8-bit space (0x80 to 0xFF) is never banked and always maps into page zero. The lower half (0x00 to 0x7F) is banked: an 8-bit bank register supplies the upper physical byte, and address bit 7 is cleared in the result. The bank register itself is reached at data address 0xFF, in the unbanked half, so it can always be reprogrammed whatever bank is selected.

Accesses flagged as stack accesses ignore the bank register and always land in bank zero. The block then decodes the physical address into RAM, the bank register, or a hole. The RAM is modelled inside the block. It holds page zero (0x0000 to 0x006F and 0x0080 to 0x00FE) plus `NUM_EXT_WIN` windows of 128 bytes at 0x0100, 0x0200 and so on. Strobed accesses to holes raise a flag, writes to holes are dropped, and reads from holes return zero.

Top module: `dseg_addr_ext`

## Requirements
- R1: When addr_i[7] is 1, paddr_o equals {8'h00, addr_i}, whatever the bank register holds and whatever stack_i is.
- R2: When addr_i[7] is 0 and stack_i is 0, paddr_o equals {bank, 1'b0, addr_i[6:0]}.
- R3: When stack_i is 1, paddr_o[15:8] is 0x00. In the lower half the offset is still addr_i[6:0].
- R4: Reset clears the bank register. A read at address 0xFF returns the bank register. A non-stack write at 0xFF loads wdata_i. The new value first applies in the cycle after the write; a read at 0xFF in the same cycle as the write returns the old value.
- R5: A write at 0xFF with stack_i at 1 leaves the bank register unchanged.
- R6: ram_sel_o is 1 only when rd_i or wr_i is 1 and paddr_o falls in 0x0000-0x006F, 0x0080-0x00FE, or bank b at offsets 0x00-0x7F for 1 <= b <= NUM_EXT_WIN. It is 0 for 0x00FF and when neither strobe is active.
- R7: With a strobe active, unmapped_o is 1 for 0x0070-0x007F and for any bank above NUM_EXT_WIN. Writes there change no stored byte, and reads return 0x00.
- R8: A byte written to a RAM location reads back unchanged. Equal offsets in different banks, and in stack versus banked accesses, are distinct locations.
- R9: rdata_o is 0x00 whenever rd_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Processor data address |
| stack_i | input | 1 | Access is stack-pointer based (forces bank zero) |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe, captured on the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| paddr_o | output | 16 | Translated physical address |
| ram_sel_o | output | 1 | Strobed access hits RAM |
| unmapped_o | output | 1 | Strobed access hits a hole |

## Verification
The checker evaluates the address formation of both halves, the forcing of bank zero by the stack flag, and the one-cycle latency of a bank write as seen at the address port. On every cycle it also checks that the two select flags exclude each other, that page-zero holes are flagged, and that hole reads and idle reads return zero. Some effects show only in the bench's scenarios: that stored bytes survive, that equal offsets in separate banks do not alias, that writes to holes are dropped, and that stack writes at 0xFF do not disturb the bank register. These require a write followed by a later readback.

// File: rtl/dseg_pkg.sv
package dseg_pkg;
    localparam int ADDR_W    = 8;
    localparam int SEG_W     = 8;
    localparam int DATA_W    = 8;
    localparam int OFS_W     = ADDR_W - 1;
    localparam int PADDR_W   = SEG_W + ADDR_W;
    localparam int PAGE0_SZ  = 1 << ADDR_W;
    localparam int WIN_SZ    = 1 << OFS_W;
    localparam logic [ADDR_W-1:0] SEGREG_ADDR = 8'hFF;
    localparam logic [ADDR_W-1:0] LOW_RAM_TOP = 8'h6F;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_SEGR = 2'd2,
        RGN_HOLE = 2'd3
    } region_e;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
    } state_t;
endpackage

// File: rtl/dseg_xlate.sv
module dseg_xlate
    import dseg_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               stack_i,
    input  logic [SEG_W-1:0]   seg_i,
    output logic [PADDR_W-1:0] paddr_o
);
    logic             banked;
    logic [SEG_W-1:0] upper;

    always_comb begin
        banked  = ~addr_i[ADDR_W-1];
        upper   = (banked && !stack_i) ? seg_i : '0;
        paddr_o = {upper, addr_i};
    end
endmodule

// File: rtl/dseg_decode.sv
module dseg_decode
    import dseg_pkg::*;
#(
    parameter int NUM_EXT_WIN = 3,
    parameter int IDX_W       = 10
) (
    input  logic [PADDR_W-1:0] paddr_i,
    output region_e            region_o,
    output logic [IDX_W-1:0]   idx_o
);
    localparam logic [SEG_W-1:0] LAST_WIN = SEG_W'(NUM_EXT_WIN);

    logic [SEG_W-1:0]  pseg;
    logic [ADDR_W-1:0] plo;

    always_comb begin
        pseg     = paddr_i[PADDR_W-1:ADDR_W];
        plo      = paddr_i[ADDR_W-1:0];
        region_o = RGN_HOLE;
        idx_o    = '0;
        if (pseg == '0) begin
            if (plo == SEGREG_ADDR) begin
                region_o = RGN_SEGR;
            end else if (plo[ADDR_W-1] || plo <= LOW_RAM_TOP) begin
                region_o = RGN_RAM;
                idx_o    = IDX_W'(plo);
            end
        end else if (pseg <= LAST_WIN && !plo[ADDR_W-1]) begin
            region_o = RGN_RAM;
            idx_o    = IDX_W'(PAGE0_SZ + (int'(pseg) - 1) * WIN_SZ + int'(plo[OFS_W-1:0]));
        end
    end
endmodule

// File: rtl/dseg_store.sv
module dseg_store
    import dseg_pkg::*;
#(
    parameter int DEPTH = 640,
    parameter int IDX_W = 10
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[idx_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[idx_i];
endmodule

// File: rtl/dseg_addr_ext.sv
module dseg_addr_ext
    import dseg_pkg::*;
#(
    parameter int NUM_EXT_WIN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               stack_i,
    input  logic               rd_i,
    input  logic               wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [PADDR_W-1:0] paddr_o,
    output logic               ram_sel_o,
    output logic               unmapped_o
);
    localparam int DEPTH = PAGE0_SZ + NUM_EXT_WIN * WIN_SZ;
    localparam int IDX_W = $clog2(DEPTH);

    state_t            st_d, st_q;
    region_e           region;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] mem_rdata;
    logic              mem_we;
    logic              access;

    dseg_xlate i_xlate (
        .addr_i  (addr_i),
        .stack_i (stack_i),
        .seg_i   (st_q.seg),
        .paddr_o (paddr_o)
    );

    dseg_decode #(.NUM_EXT_WIN(NUM_EXT_WIN), .IDX_W(IDX_W)) i_decode (
        .paddr_i  (paddr_o),
        .region_o (region),
        .idx_o    (idx)
    );

    dseg_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_store (
        .clk     (clk),
        .we_i    (mem_we),
        .idx_i   (idx),
        .wdata_i (wdata_i),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        st_d       = st_q;
        access     = rd_i | wr_i;
        ram_sel_o  = access && (region == RGN_RAM);
        unmapped_o = access && (region == RGN_HOLE);
        mem_we     = wr_i && (region == RGN_RAM);
        if (wr_i && !stack_i && region == RGN_SEGR) begin
            st_d.seg = wdata_i;
        end
        rdata_o = '0;
        if (rd_i) begin
            case (region)
                RGN_RAM:  rdata_o = mem_rdata;
                RGN_SEGR: rdata_o = st_q.seg;
                default:  rdata_o = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dseg_addr_ext_chk.sv
module dseg_addr_ext_chk
    import dseg_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  addr_i,
    input logic               stack_i,
    input logic               rd_i,
    input logic               wr_i,
    input logic [DATA_W-1:0]  wdata_i,
    input logic [DATA_W-1:0]  rdata_o,
    input logic [PADDR_W-1:0] paddr_o,
    input logic               ram_sel_o,
    input logic               unmapped_o
);
    p_upper_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_i[7] |-> paddr_o == {8'h00, addr_i});

    p_lower_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_i[7] |-> paddr_o[7:0] == {1'b0, addr_i[6:0]});

    p_stack_seg0_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stack_i |-> paddr_o[15:8] == 8'h00);

    p_seg_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_i && !stack_i && addr_i == 8'hFF)
         && !addr_i[7] && !stack_i) |-> paddr_o[15:8] == $past(wdata_i));

    p_sel_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_sel_o || unmapped_o) |-> ((rd_i || wr_i) && !(ram_sel_o && unmapped_o)));

    p_hole_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_i || wr_i) && paddr_o[15:4] == 12'h007) |-> unmapped_o);

    p_hole_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_o |-> rdata_o == 8'h00);

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> rdata_o == 8'h00);
endmodule

bind dseg_addr_ext dseg_addr_ext_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_i     (addr_i),
    .stack_i    (stack_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .paddr_o    (paddr_o),
    .ram_sel_o  (ram_sel_o),
    .unmapped_o (unmapped_o)
);

// File: tb/test_dseg_addr_ext.sv
`timescale 1ns/1ps
module test_dseg_addr_ext;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        stack = 1'b0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [15:0] paddr;
    logic        ram_sel;
    logic        unmapped;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    dseg_addr_ext #(.NUM_EXT_WIN(3)) i_dseg_addr_ext (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .stack_i    (stack),
        .rd_i       (rd),
        .wr_i       (wr),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .paddr_o    (paddr),
        .ram_sel_o  (ram_sel),
        .unmapped_o (unmapped)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  seg;
        logic        stk;
        logic [7:0]  a;
        logic [15:0] pa;
        logic        ram;
        logic        unm;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VEC [NVEC] = '{
        '{4'd1, 8'h00, 1'b0, 8'h85, 16'h0085, 1'b1, 1'b0}, // R1 page-zero upper half
        '{4'd2, 8'h00, 1'b0, 8'h10, 16'h0010, 1'b1, 1'b0}, // R2 bank zero RAM
        '{4'd7, 8'h00, 1'b0, 8'h75, 16'h0075, 1'b0, 1'b1}, // R7 page-zero hole
        '{4'd2, 8'h01, 1'b0, 8'h10, 16'h0110, 1'b1, 1'b0}, // R2 bank one
        '{4'd6, 8'h02, 1'b0, 8'h7F, 16'h027F, 1'b1, 1'b0}, // R6 top of bank two
        '{4'd6, 8'h03, 1'b0, 8'h00, 16'h0300, 1'b1, 1'b0}, // R6 last window
        '{4'd7, 8'h04, 1'b0, 8'h20, 16'h0420, 1'b0, 1'b1}, // R7 bank past windows
        '{4'd3, 8'h03, 1'b1, 8'h20, 16'h0020, 1'b1, 1'b0}, // R3 stack forces bank zero
        '{4'd3, 8'h05, 1'b1, 8'h72, 16'h0072, 1'b0, 1'b1}, // R3 stack into hole
        '{4'd1, 8'hAB, 1'b0, 8'hC4, 16'h00C4, 1'b1, 1'b0}, // R1 bank ignored in upper half
        '{4'd7, 8'hAB, 1'b0, 8'h33, 16'hAB33, 1'b0, 1'b1}, // R7 far bank
        '{4'd6, 8'h01, 1'b0, 8'hFF, 16'h00FF, 1'b0, 1'b0}  // R6 bank register not RAM
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_seg(input logic [7:0] v);
        @(negedge clk);
        addr = 8'hFF; stack = 1'b0; rd = 1'b0; wr = 1'b1; wdata = v;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wr_mem(input logic [7:0] a, input logic s, input logic [7:0] d);
        @(negedge clk);
        addr = a; stack = s; rd = 1'b0; wr = 1'b1; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic s, input logic [7:0] e, input string req);
        @(negedge clk);
        addr = a; stack = s; wr = 1'b0; rd = 1'b1;
        #1;
        chk(req, {8'h00, rdata}, {8'h00, e});
        rd = 1'b0;
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: R4 bank cleared, R9 idle read zero, R2 bank zero used
        @(negedge clk);
        addr = 8'h10; #1;
        chk("R2", paddr, 16'h0010);
        chk("R9", {8'h00, rdata}, 16'h0000);
        chk("R6", {15'h0, ram_sel}, 16'h0000);
        rd_chk(8'hFF, 1'b0, 8'h00, "R4");

        // Table of translation vectors
        for (int i = 0; i < NVEC; i++) begin
            set_seg(VEC[i].seg);
            addr = VEC[i].a; stack = VEC[i].stk; rd = 1'b1;
            #1;
            chk($sformatf("R%0d paddr row %0d", VEC[i].req, i), paddr, VEC[i].pa);
            chk($sformatf("R%0d ram_sel row %0d", VEC[i].req, i), {15'h0, ram_sel}, {15'h0, VEC[i].ram});
            chk($sformatf("R%0d unmapped row %0d", VEC[i].req, i), {15'h0, unmapped}, {15'h0, VEC[i].unm});
            rd = 1'b0;
        end

        // R4: write applies next cycle; same-cycle read returns old value (01)
        @(negedge clk);
        addr = 8'hFF; stack = 1'b0; rd = 1'b1; wr = 1'b1; wdata = 8'h07;
        #1;
        chk("R4 same cycle", {8'h00, rdata}, 16'h0001);
        @(negedge clk);
        wr = 1'b0; #1;
        chk("R4 next cycle", {8'h00, rdata}, 16'h0007);
        rd = 1'b0;
        addr = 8'h10; #1;
        chk("R4 new bank used", paddr, 16'h0710);

        // R5: stack write at 0xFF leaves bank register alone
        wr_mem(8'hFF, 1'b1, 8'h55);
        rd_chk(8'hFF, 1'b0, 8'h07, "R5");

        // R8: storage and distinct locations
        set_seg(8'h01); wr_mem(8'h05, 1'b0, 8'hA1);
        set_seg(8'h02); wr_mem(8'h05, 1'b0, 8'hB2);
        wr_mem(8'h05, 1'b1, 8'hC3);
        wr_mem(8'hFC, 1'b0, 8'hD4);
        set_seg(8'h01); rd_chk(8'h05, 1'b0, 8'hA1, "R8 bank1");
        set_seg(8'h02); rd_chk(8'h05, 1'b0, 8'hB2, "R8 bank2");
        rd_chk(8'h05, 1'b1, 8'hC3, "R8 stack");
        rd_chk(8'hFC, 1'b0, 8'hD4, "R8 register area");
        set_seg(8'h00); rd_chk(8'h05, 1'b0, 8'hC3, "R8 bank0");

        // R7: hole writes dropped, reads zero
        wr_mem(8'h75, 1'b0, 8'hEE);
        rd_chk(8'h75, 1'b0, 8'h00, "R7 page-zero hole");
        set_seg(8'h04); wr_mem(8'h05, 1'b0, 8'h99);
        rd_chk(8'h05, 1'b0, 8'h00, "R7 far bank");
        set_seg(8'h01); rd_chk(8'h05, 1'b0, 8'hA1, "R7 no alias");

        // R9: stored byte not visible without read strobe
        @(negedge clk);
        addr = 8'h05; stack = 1'b0; rd = 1'b0; wr = 1'b0; #1;
        chk("R9 idle", {8'h00, rdata}, 16'h0000);

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule